// File: doc/BRIEF.md
# Periodic Interval Timer with Byte-Wide Register Access

This block is a 22-bit free-running periodic timer for board-level glue logic. It counts from zero up to a programmable terminal value, returns to zero, and repeats. When a 66 MHz strap input is high, the input clock is divided by two, so the count rate stays the same for either board clock. At every wrap the timer can raise a level interrupt.

Software reaches the timer through a small byte-wide register window. Reading latch byte 0 freezes the whole count into a holding register. The other three latch bytes then return pieces of that frozen value, so a multi-byte read stays consistent while the counter keeps running. The terminal value is written through three byte registers. A control register holds a run bit and an interrupt-enable bit. To acknowledge an interrupt, software drops interrupt-enable and then raises it again.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the run bit and the interrupt-enable bit are 0, `irq` is 0, `bus_rdata` is 0, and the terminal value is all ones (0x3FFFFF).
- R2: With run = 1 and `strap_fast` = 0, the count rises by one on every clock. With run = 0, the count holds its value.
- R3: With `strap_fast` = 1, the count advances on at most every second clock. A phase flag toggles on each clock while the strap is high and is held at 0 while the strap is low. A count step happens only when run = 1 and either the strap is low or the phase flag is 1.
- R4: On a count step taken while the count is greater than or equal to the terminal value, the count goes to 0 instead of incrementing.
- R5: Terminal writes use these addresses:
  - Address 0 loads terminal bits 7:0.
  - Address 1 loads bits 15:8.
  - Address 2 loads bits 21:16 from write-data bits 5:0. Write-data bits 7:6 are ignored.
  - A terminal write while run = 0 also clears the count to 0.
  - Writes to address 3 and to addresses 5 to 7 change nothing.
- R6: A read of address 0 copies the current count into a holding register. Reads of addresses 1 to 3 return bytes of that held value, and later counting does not change them.
- R7: Latch bytes 0, 1 and 2 carry count groups 5:0, 11:6 and 17:12. Each byte has the group's bits 4:0 in bits 4:0 and the group's bit 5 in bit 6. Bits 5 and 7 read as 0. Byte 3 carries count bits 21:18 in bits 3:0, and its upper 4 bits read as 0.
- R8: Address 4 is the control register: bit 0 is run and bit 1 is interrupt-enable. Both read back, and the other bits read as 0.
- R9: A pending flag sets on each wrap that occurs while interrupt-enable is 1. `irq` equals that flag. No wrap sets it while interrupt-enable is 0.
- R10: Writing interrupt-enable = 0 clears the pending flag. This clear wins over a wrap in the same cycle. Turning interrupt-enable off and then on acknowledges the interrupt.
- R11: Read data appears in `bus_rdata` on the clock after the read strobe. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_fast | input | 1 | High when the board clock is twice the count rate |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt (pending flag) |

## Verification
The count path is tried in four ways:
- Undivided clock against a divided one, which separates the per-clock step from the every-other-clock step.
- A small terminal of 5, written with junk in the upper bits of the third byte. This shows whether those bits are masked and whether the wrap lands on the terminal value.
- Snapshot reads with idle gaps between the bytes. These distinguish a frozen holding register from live reads.
- A random mix of strap changes, control writes, terminal writes and reads, compared against a cycle model. This catches interactions such as a terminal write while stopped, and an interrupt-enable clear that coincides with a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 22;
  localparam int GRP_W  = 6;
  localparam int BYTE_W = 8;
  localparam int NGRP   = 3;
  localparam int TOP_W  = CNT_W - NGRP * GRP_W;

  typedef enum logic [2:0] {
    A_LAT0 = 3'd0,
    A_LAT1 = 3'd1,
    A_LAT2 = 3'd2,
    A_LAT3 = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;

  // Six count bits into one latch byte: [4:0] low bits, [6] top bit, gaps zero.
  function automatic logic [BYTE_W-1:0] pack_grp(input logic [GRP_W-1:0] g);
    logic [BYTE_W-1:0] b;
    b      = '0;
    b[4:0] = g[4:0];
    b[6]   = g[5];
    return b;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale (
  input  logic clk,
  input  logic rst,
  input  logic strap_fast,
  input  logic run,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)             phase_q <= 1'b0;
    else if (strap_fast) phase_q <= ~phase_q;
    else                 phase_q <= 1'b0;
  end

  assign tick = run && (!strap_fast || phase_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q >= term);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter logic [CNT_W-1:0] TERM_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  output logic              run,
  output logic              ie,
  output logic              clr,
  output logic [CNT_W-1:0]  term,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0]  term_q, term_d, hold_q;
  logic              run_q, ie_q, pend_q;
  logic [BYTE_W-1:0] rdata_q, rd_mux;
  logic [BYTE_W-1:0] lat_byte [NGRP+1];
  logic              term_wr, ctrl_wr, ie_clear;

  assign term_wr  = bus_wr && (bus_addr <= A_LAT2);
  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign ie_clear = ctrl_wr && !bus_wdata[1];
  assign clr      = term_wr && !run_q;

  always_comb begin
    term_d = term_q;
    for (int b = 0; b < NGRP; b++) begin
      if (term_wr && bus_addr == 3'(b)) begin
        for (int i = 0; i < BYTE_W; i++) begin
          if (b * BYTE_W + i < CNT_W) term_d[b*BYTE_W+i] = bus_wdata[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      term_q <= TERM_RESET;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      term_q <= term_d;
      if (ctrl_wr) begin
        run_q <= bus_wdata[0];
        ie_q  <= bus_wdata[1];
      end
      if (ie_clear)         pend_q <= 1'b0;
      else if (wrap && ie_q) pend_q <= 1'b1;
    end
  end

  // Latch byte 0 comes from the live count; the rest from the held copy.
  for (genvar g = 0; g < NGRP; g++) begin : g_lat
    if (g == 0) begin : g_live
      assign lat_byte[g] = pack_grp(count[GRP_W-1:0]);
    end else begin : g_held
      assign lat_byte[g] = pack_grp(hold_q[g*GRP_W +: GRP_W]);
    end
  end
  assign lat_byte[NGRP] = BYTE_W'(hold_q[CNT_W-1 -: TOP_W]);

  always_comb begin
    rd_mux = '0;
    if (bus_addr <= A_LAT3) rd_mux = lat_byte[bus_addr[1:0]];
    else if (bus_addr == A_CTRL) rd_mux = BYTE_W'({ie_q, run_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
      if (bus_addr == A_LAT0) hold_q <= count;
    end
  end

  assign run       = run_q;
  assign ie        = ie_q;
  assign term      = term_q;
  assign bus_rdata = rdata_q;
  assign irq       = pend_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter logic [CNT_W-1:0] TERM_RESET = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_fast,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic             run_w, ie_w, clr_w, tick_w, wrap_w;
  logic [CNT_W-1:0] term_w, count_w;

  tmr_prescale u_pre (
    .clk(clk), .rst(rst), .strap_fast(strap_fast), .run(run_w), .tick(tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .clr(clr_w), .term(term_w),
    .count(count_w), .wrap(wrap_w)
  );

  tmr_regs #(.TERM_RESET(TERM_RESET)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .count(count_w), .wrap(wrap_w), .run(run_w),
    .ie(ie_w), .clr(clr_w), .term(term_w), .bus_rdata(bus_rdata), .irq(irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              strap_fast,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              irq,
  input logic              run_w,
  input logic              ie_w,
  input logic              clr_w,
  input logic              tick_w,
  input logic              wrap_w,
  input logic [CNT_W-1:0]  count_w
);
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_w && !clr_w) |=> $stable(count_w));

  a_r3_half_rate: assert property (@(posedge clk) disable iff (rst)
    (tick_w && strap_fast) |=> (!tick_w || !strap_fast));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> (count_w == '0));

  a_r9_irq_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (wrap_w && ie_w && !(bus_wr && bus_addr == A_CTRL && !bus_wdata[1])) |=> irq);

  a_r10_no_irq_without_ie: assert property (@(posedge clk) disable iff (rst)
    !ie_w |-> !irq);

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > A_CTRL) |=> (bus_rdata == '0));
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rst(rst), .strap_fast(strap_fast), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .run_w(run_w), .ie_w(ie_w), .clr_w(clr_w), .tick_w(tick_w),
  .wrap_w(wrap_w), .count_w(count_w)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_fast = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .strap_fast(strap_fast), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Reference model built from the requirements.
  logic [21:0] m_cnt, m_term, m_hold;
  logic        m_run, m_ie, m_pend, m_phase;
  logic [7:0]  m_rdata;
  logic        m_tick, m_wrap;

  function automatic logic [7:0] pk(input logic [5:0] g);
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction

  function automatic logic [21:0] unpk(input logic [7:0] b0, b1, b2, b3);
    return {b3[3:0], b2[6], b2[4:0], b1[6], b1[4:0], b0[6], b0[4:0]};
  endfunction

  assign m_tick = m_run && (!strap_fast || m_phase);
  assign m_wrap = m_tick && (m_cnt >= m_term);

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0; m_term <= '1; m_hold <= '0; m_run <= 0; m_ie <= 0;
      m_pend <= 0; m_phase <= 0; m_rdata <= '0;
    end else begin
      m_phase <= strap_fast ? ~m_phase : 1'b0;
      if (bus_wr && bus_addr <= 2 && !m_run) m_cnt <= '0;
      else if (m_wrap) m_cnt <= '0;
      else if (m_tick) m_cnt <= m_cnt + 1;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_term[7:0]   <= bus_wdata;
          3'd1: m_term[15:8]  <= bus_wdata;
          3'd2: m_term[21:16] <= bus_wdata[5:0];
          3'd4: begin m_run <= bus_wdata[0]; m_ie <= bus_wdata[1]; end
          default: ;
        endcase
      end
      if (bus_wr && bus_addr == 3'd4 && !bus_wdata[1]) m_pend <= 1'b0;
      else if (m_wrap && m_ie) m_pend <= 1'b1;
      if (bus_rd) begin
        case (bus_addr)
          3'd0: begin m_hold <= m_cnt; m_rdata <= pk(m_cnt[5:0]); end
          3'd1: m_rdata <= pk(m_hold[11:6]);
          3'd2: m_rdata <= pk(m_hold[17:12]);
          3'd3: m_rdata <= {4'b0, m_hold[21:18]};
          3'd4: m_rdata <= {6'b0, m_ie, m_run};
          default: m_rdata <= '0;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Snapshot read with a gap between bytes; checks packing and held value.
  task automatic read_count(input string req, input int gap, output logic [21:0] v);
    logic [7:0] b [4];
    logic [21:0] snap;
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), b[i]);
      if (i == 0) snap = m_hold;
      check(req, b[i], m_rdata);
      idle(gap);
    end
    check("R7 gap bits", {b[0][7], b[0][5], b[1][7], b[1][5], b[2][7], b[2][5], b[3][7:4]}, '0);
    v = unpk(b[0], b[1], b[2], b[3]);
    check("R6 snapshot", v, snap);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [21:0] v;
    bit          seen;
    void'($urandom(32'h5eed1234));
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 irq", irq, 1'b0);
    check("R1 rdata", bus_rdata, 8'h00);
    rd(3'd4, d); check("R1 R8 ctrl", d, 8'h00);
    read_count("R1 count", 0, v); check("R1 count zero", v, 22'd0);
    // R2 stopped holds
    idle(10); read_count("R2 stopped", 0, v); check("R2 held zero", v, 22'd0);
    // R2 run undivided: snapshot delta across a known gap
    wr(3'd4, 8'h01);
    rd(3'd4, d); check("R8 ctrl readback", d, 8'h01);
    read_count("R2 run", 0, v);
    begin
      logic [21:0] v2;
      read_count("R2 run", 0, v2);
      check("R2 step per clock", v2 - v, 22'd8);
    end
    // R6 gap between bytes must not alter held bytes
    read_count("R6 gapped", 13, v);
    // R3 divided clock
    wr(3'd4, 8'h00); wr(3'd0, 8'hFF);
    strap_fast = 1'b1;
    wr(3'd4, 8'h01);
    read_count("R3 div", 0, v);
    begin
      logic [21:0] v2;
      read_count("R3 div", 0, v2);
      check("R3 half rate", v2 - v, 22'd4);
    end
    strap_fast = 1'b0;
    // R5 terminal = 5 with junk in byte 2 upper bits; R4 wrap; R9 irq
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'hC0);
    read_count("R5 cleared", 0, v); check("R5 clear on term write", v, 22'd0);
    wr(3'd4, 8'h03);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      idle(1);
      if (irq) seen = 1;
    end
    check("R5 R9 irq after wrap at 5", seen, 1'b1);
    for (int i = 0; i < 6; i++) begin
      read_count("R4 wrap", 0, v);
      check("R4 count within terminal", v <= 22'd5, 1'b1);
    end
    // R10 ack by ie off/on
    wr(3'd4, 8'h01); idle(1); check("R10 clear on ie off", irq, 1'b0);
    idle(20); check("R9 no irq with ie off", irq, 1'b0);
    wr(3'd4, 8'h03); check("R10 still clear after ie on", irq, m_pend);
    idle(10); check("R9 irq rearmed", irq, 1'b1);
    // R11 unmapped addresses and write ignore
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); check("R11 unmapped", d, 8'h00);
    end
    wr(3'd3, 8'hFF); wr(3'd5, 8'hFF);
    rd(3'd4, d); check("R5 ignored writes", d, 8'h03);
    // Random mix against the model
    for (int it = 0; it < 500; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [2:0] a;
        logic [7:0] wd;
        a = 3'($urandom_range(0, 7));
        wd = 8'($urandom);
        if (a == 3'd2 || a == 3'd1) wd = (($urandom_range(0, 3) == 0) ? wd : 8'h00);
        wr(a, wd);
      end else if (op < 6) begin
        rd(3'($urandom_range(0, 7)), d);
        check("R6 R7 R8 R11 random read", d, m_rdata);
      end else if (op < 8) begin
        read_count("R2 R4 random count", $urandom_range(0, 3), v);
      end else if (op == 8) begin
        @(negedge clk); strap_fast = ~strap_fast;
      end else begin
        idle($urandom_range(1, 8));
      end
      check("R9 R10 random irq", irq, m_pend);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule